// File: doc/BRIEF.md
# Replicated Operand Store with Address-Mapped Ports

This block is the single data store of a three-operand, multithreaded processor. It replaces both the register file and the data RAM. Every operand address in an instruction names a location in one flat space, so there are no load or store instructions. Two identical copies of the store, A and B, are kept. Each copy is read with its own operand address, so both source operands arrive in the same cycle.

Each result from the execution unit is written into both copies, which keeps them identical. When the result address falls inside a window reserved for instruction words, the result is also sent out on an instruction-memory write port. A small window at the top of the address space does not use RAM. Reads there return external input ports. Writes there pulse a per-port strobe and carry the result word out.

The RAM sits between an input register stage and a registered read. Both the read path and the write path are therefore exactly two stages deep.

Top module: `opmem_replicated`

## Requirements
- R1: Each read port returns the word at its own address after two rising edges: an address presented in the cycle before edge k appears on the data output after edge k+1. The A and B ports are addressed independently.
- R2: A write lands in both copies, so after the write takes effect, reading that address on port A and on port B returns the same written word.
- R3: A read presented in the same cycle as a write to the same address returns the old word. A read presented one cycle later returns the new word.
- R4: A read of an address in the port window (IO_BASE to IO_BASE+IO_PORTS-1) returns input port p = address − IO_BASE, where port p occupies bits [p*W +: W] of `io_in`. The value is sampled at the second edge after the address is presented, which is the same edge at which a RAM read is captured.
- R5: A write to the port window raises `io_wr_strobe` bit p = address − IO_BASE for exactly the one cycle after the write is presented, with `io_out_data` equal to the written word. At most one strobe bit is ever high.
- R6: A write to the instruction window (IMEM_BASE to IMEM_BASE+IMEM_DEPTH-1) raises `imem_wr_en` for the one cycle after the write is presented, with `imem_wr_addr` = address − IMEM_BASE and `imem_wr_data` equal to the word. The word is also stored in both copies.
- R7: With `wr_en` low, no location changes, no strobe rises and `imem_wr_en` stays low.
- R8: During and right after reset, both read data outputs are zero, `io_wr_strobe` is zero and `imem_wr_en` is low.
- R9: A write outside the instruction window, including one to the port window, leaves `imem_wr_en` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rd_a_addr | input | AW | Operand address for copy A |
| rd_b_addr | input | AW | Operand address for copy B |
| rd_a_data | output | W | Registered read data from copy A |
| rd_b_data | output | W | Registered read data from copy B |
| wr_en | input | 1 | Result write request |
| wr_addr | input | AW | Result address |
| wr_data | input | W | Result word |
| io_in | input | IO_PORTS*W | Input port words, port p at bits [p*W +: W] |
| io_out_data | output | W | Word written to the port window |
| io_wr_strobe | output | IO_PORTS | One-cycle write strobe per output port |
| imem_wr_en | output | 1 | Instruction-memory write request |
| imem_wr_addr | output | IAW | Offset within the instruction window |
| imem_wr_data | output | W | Word for instruction memory |

## Verification
If the two copies ever diverge, the fault shows two edges after the same address is placed on both read ports: A and B return different words. A write register that is stale or held too long shows up one cycle after the write as a strobe or an instruction-memory write that is missing, late or repeated. A port read captured at the wrong edge returns the input value from a neighbouring cycle, so the bench changes `io_in` on every cycle to expose it.

// File: rtl/opmem_replicated.sv
module opmem_replicated #(
  parameter int W          = 36,
  parameter int DEPTH      = 1024,
  parameter int IO_PORTS   = 4,
  parameter int IO_BASE    = DEPTH - IO_PORTS,
  parameter int IMEM_BASE  = DEPTH / 2,
  parameter int IMEM_DEPTH = 256,
  localparam int AW  = $clog2(DEPTH),
  localparam int IAW = (IMEM_DEPTH > 1) ? $clog2(IMEM_DEPTH) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [AW-1:0]         rd_a_addr,
  input  logic [AW-1:0]         rd_b_addr,
  output logic [W-1:0]          rd_a_data,
  output logic [W-1:0]          rd_b_data,
  input  logic                  wr_en,
  input  logic [AW-1:0]         wr_addr,
  input  logic [W-1:0]          wr_data,
  input  logic [IO_PORTS*W-1:0] io_in,
  output logic [W-1:0]          io_out_data,
  output logic [IO_PORTS-1:0]   io_wr_strobe,
  output logic                  imem_wr_en,
  output logic [IAW-1:0]        imem_wr_addr,
  output logic [W-1:0]          imem_wr_data
);

  localparam int PW = (IO_PORTS > 1) ? $clog2(IO_PORTS) : 1;
  localparam logic [AW:0] IO_LO = (AW+1)'(IO_BASE);
  localparam logic [AW:0] IO_HI = (AW+1)'(IO_BASE + IO_PORTS);
  localparam logic [AW:0] IM_LO = (AW+1)'(IMEM_BASE);
  localparam logic [AW:0] IM_HI = (AW+1)'(IMEM_BASE + IMEM_DEPTH);

  function automatic logic in_io(input logic [AW-1:0] a);
    return ({1'b0, a} >= IO_LO) && ({1'b0, a} < IO_HI);
  endfunction

  function automatic logic [PW-1:0] io_idx(input logic [AW-1:0] a);
    return PW'(a - IO_LO[AW-1:0]);
  endfunction

  // write-side input register stage
  logic          w_en_q;
  logic [AW-1:0] w_addr_q;
  logic [W-1:0]  w_data_q;
  logic          w_io;

  always_ff @(posedge clk) begin
    if (rst) begin
      w_en_q   <= 1'b0;
      w_addr_q <= '0;
      w_data_q <= '0;
    end else begin
      w_en_q   <= wr_en;
      w_addr_q <= wr_addr;
      w_data_q <= wr_data;
    end
  end

  assign w_io = in_io(w_addr_q);

  logic [W-1:0] io_word [IO_PORTS];
  for (genvar p = 0; p < IO_PORTS; p++) begin : g_port
    assign io_word[p]      = io_in[p*W +: W];
    assign io_wr_strobe[p] = w_en_q && ({1'b0, w_addr_q} == IO_LO + (AW+1)'(p));
  end

  assign io_out_data  = w_data_q;
  assign imem_wr_en   = w_en_q && ({1'b0, w_addr_q} >= IM_LO) && ({1'b0, w_addr_q} < IM_HI);
  assign imem_wr_addr = IAW'(w_addr_q - IM_LO[AW-1:0]);
  assign imem_wr_data = w_data_q;

  // two identical copies, one per operand
  logic [1:0][AW-1:0] rd_addr;
  logic [1:0][W-1:0]  rd_data;
  assign rd_addr[0] = rd_a_addr;
  assign rd_addr[1] = rd_b_addr;

  for (genvar c = 0; c < 2; c++) begin : g_copy
    logic [W-1:0]  ram [DEPTH];
    logic [AW-1:0] addr_q;
    logic [W-1:0]  dout_q;

    always_ff @(posedge clk)
      if (w_en_q && !w_io) ram[w_addr_q] <= w_data_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        addr_q <= '0;
        dout_q <= '0;
      end else begin
        addr_q <= rd_addr[c];
        dout_q <= in_io(addr_q) ? io_word[io_idx(addr_q)] : ram[addr_q];
      end
    end

    assign rd_data[c] = dout_q;
  end

  assign rd_a_data = rd_data[0];
  assign rd_b_data = rd_data[1];

  // cycles since reset, used to keep $past windows inside the post-reset interval
  logic [1:0] since_rst;
  always_ff @(posedge clk)
    if (rst) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;

  p_copies_agree_r2: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd3 && $past(rd_a_addr, 2) == $past(rd_b_addr, 2)) |-> rd_a_data == rd_b_data);

  p_port_read_stage_r4: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd3 && $past(rd_a_addr, 2) == IO_LO[AW-1:0]) |-> rd_a_data == $past(io_in[W-1:0]));

  p_strobe_onehot_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(io_wr_strobe));

  p_strobe_follows_write_r5: assert property (@(posedge clk) disable iff (rst)
    (since_rst != 2'd0 && io_wr_strobe != '0) |-> ($past(wr_en) && io_out_data == $past(wr_data)));

  p_imem_follows_write_r6: assert property (@(posedge clk) disable iff (rst)
    (since_rst != 2'd0 && imem_wr_en) |-> ($past(wr_en) && imem_wr_data == $past(wr_data)));

  p_imem_not_port_r9: assert property (@(posedge clk) disable iff (rst)
    imem_wr_en |-> io_wr_strobe == '0);

endmodule

// File: tb/sim_opmem_replicated.sv
`timescale 1ns/1ps
module sim_opmem_replicated;
  localparam int W = 36, DEPTH = 1024, AW = 10, IOP = 4;
  localparam int IO_BASE = 1020, IMB = 512, IMD = 256, IAW = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst;
  logic [AW-1:0] rd_a_addr, rd_b_addr, wr_addr;
  logic [W-1:0] rd_a_data, rd_b_data, wr_data, io_out_data, imem_wr_data;
  logic wr_en, imem_wr_en;
  logic [IOP*W-1:0] io_in, io_seen;
  logic [IOP-1:0] io_wr_strobe;
  logic [IAW-1:0] imem_wr_addr;

  opmem_replicated u0 (
    .clk(clk), .rst(rst), .rd_a_addr(rd_a_addr), .rd_b_addr(rd_b_addr),
    .rd_a_data(rd_a_data), .rd_b_data(rd_b_data), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .io_in(io_in), .io_out_data(io_out_data), .io_wr_strobe(io_wr_strobe),
    .imem_wr_en(imem_wr_en), .imem_wr_addr(imem_wr_addr), .imem_wr_data(imem_wr_data));

  typedef struct {
    int due; bit rd;
    bit ioa, iob; int pa, pb; logic [W-1:0] ea, eb;
    logic [IOP-1:0] stb; logic [W-1:0] od; bit im; logic [IAW-1:0] ia;
    string req;
  } exp_t;

  exp_t q[$];
  logic [W-1:0] model [DEPTH];
  int cyc = 0, checks = 0, errors = 0;
  bit done = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    io_seen <= io_in;
  end

  function automatic bit is_io(input logic [AW-1:0] a);
    return a >= IO_BASE && a < IO_BASE + IOP;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  // driver: one cycle of stimulus, expectations pushed to the scoreboard
  task automatic op(input logic [AW-1:0] ra, input logic [AW-1:0] rb, input bit we,
                    input logic [AW-1:0] wa, input logic [W-1:0] wd, input string req);
    exp_t e, s;
    @(negedge clk);
    rd_a_addr = ra; rd_b_addr = rb; wr_en = we; wr_addr = wa; wr_data = wd;
    for (int i = 0; i < IOP; i++) io_in[i*W +: W] = W'({$urandom(), $urandom()});
    e = '{default: 0};
    e.due = cyc + 2; e.rd = 1; e.req = req;
    e.ioa = is_io(ra); e.pa = int'(ra) - IO_BASE; e.ea = e.ioa ? '0 : model[ra];
    e.iob = is_io(rb); e.pb = int'(rb) - IO_BASE; e.eb = e.iob ? '0 : model[rb];
    s = '{default: 0};
    s.due = cyc + 1; s.rd = 0; s.req = "R5 R6 R7 R9";
    s.stb = (we && is_io(wa)) ? IOP'(1 << (int'(wa) - IO_BASE)) : '0;
    s.od = wd;
    s.im = we && wa >= IMB && wa < IMB + IMD;
    s.ia = IAW'(int'(wa) - IMB);
    if (we && !is_io(wa)) model[wa] = wd;
    q.push_back(e);
    q.push_back(s);
  endtask

  // monitor: pops due items and compares against the ports
  always @(negedge clk) begin
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].due == cyc) begin
        if (q[i].rd) begin
          chk(rd_a_data === (q[i].ioa ? io_seen[q[i].pa*W +: W] : q[i].ea), q[i].req, "port A read",
              rd_a_data, q[i].ioa ? io_seen[q[i].pa*W +: W] : q[i].ea);
          chk(rd_b_data === (q[i].iob ? io_seen[q[i].pb*W +: W] : q[i].eb), q[i].req, "port B read",
              rd_b_data, q[i].iob ? io_seen[q[i].pb*W +: W] : q[i].eb);
        end else begin
          chk(io_wr_strobe === q[i].stb, q[i].req, "strobe", W'(io_wr_strobe), W'(q[i].stb));
          if (q[i].stb != '0) chk(io_out_data === q[i].od, q[i].req, "port out data", io_out_data, q[i].od);
          chk(imem_wr_en === q[i].im, q[i].req, "imem enable", W'(imem_wr_en), W'(q[i].im));
          if (q[i].im) begin
            chk(imem_wr_addr === q[i].ia, q[i].req, "imem addr", W'(imem_wr_addr), W'(q[i].ia));
            chk(imem_wr_data === q[i].od, q[i].req, "imem data", imem_wr_data, q[i].od);
          end
        end
        q.delete(i);
      end
    end
  end

  function automatic logic [AW-1:0] pick();
    int r = $urandom % 10;
    if (r < 6) return AW'($urandom % 64);
    if (r < 8) return AW'(IMB + $urandom % 8);
    return AW'(IO_BASE + $urandom % IOP);
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    rst = 1; wr_en = 0; rd_a_addr = '0; rd_b_addr = '0; wr_addr = '0; wr_data = '0; io_in = '0;
    repeat (4) @(negedge clk);
    // R8: reset values
    chk(rd_a_data === '0, "R8", "A after reset", rd_a_data, '0);
    chk(rd_b_data === '0, "R8", "B after reset", rd_b_data, '0);
    chk(io_wr_strobe === '0, "R8", "strobe after reset", W'(io_wr_strobe), '0);
    chk(imem_wr_en === 1'b0, "R8", "imem after reset", W'(imem_wr_en), '0);
    rst = 0;

    // fill low RAM; first op reads ports only (R4)
    for (int a = 0; a < 64; a++)
      op(AW'(a == 0 ? IO_BASE : 0), AW'(a == 0 ? IO_BASE + 3 : 0), 1, AW'(a),
         W'(36'h5A000 + a * 7), "R1 R2 R4");
    // instruction window writes (R6)
    for (int a = 0; a < 8; a++)
      op(AW'(a), AW'(63 - a), 1, AW'(IMB + a), W'(36'hC0000000 + a), "R1 R6");
    // read-during-write old data, then new (R3)
    op(5, 5, 1, 5, 36'hFEEDBEEF1, "R3 same-cycle old");
    op(5, 5, 0, 5, '0, "R3 next-cycle new");
    // write disabled (R7)
    op(7, 6, 0, 7, 36'h123456789, "R7 no write");
    op(7, 7, 0, 0, '0, "R7 unchanged");
    op(7, AW'(IMB + 2), 0, 0, '0, "R2 R6 stored copies");
    // port window writes and reads (R4, R5, R9)
    for (int p = 0; p < IOP; p++) op(AW'(IO_BASE + p), AW'(IO_BASE + IOP - 1 - p), 1,
                                     AW'(IO_BASE + p), W'(36'h900000000 + p), "R4 R5 R9");
    // mixed traffic
    for (int n = 0; n < 400; n++) begin
      logic [AW-1:0] ra, rb, wa;
      ra = pick(); rb = ($urandom % 3 == 0) ? ra : pick(); wa = pick();
      op(ra, rb, 1'($urandom % 2), wa, W'({$urandom(), $urandom()}), "R1 R2 R3 R4 R5 R6");
    end
    for (int n = 0; n < 4; n++) op(0, 0, 0, 0, '0, "R1 R7");
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule